// File: doc/BRIEF.md
# Synchronous Host-Bus Register and Buffer Slave

This block sits on the FPGA side of a 16-bit synchronous parallel host bus with separate address and data lines. The host opens every access with a low chip select. Reads also pull output enable low and writes pull write enable low. Each access runs for a fixed number of bus clocks, and the slave never stalls it. Writes from the host fill a waveform sample RAM that a DDS engine reads through its own port. They also load a 32-bit frequency control word. Reads from the host return words from an acquisition buffer, which the capture logic fills through a separate write port.

Timing is counted in bus clock edges and needs no handshake. Access edge 1 is the first rising edge that samples chip select low, and later edges are numbered on from there. The host samples read data at access edge 11, so the slave loads its output register at edge 10. A write takes the data bus value at access edge 11. The pad ring uses the registered enable output to drive the shared data pins. The required three-clock gap between accesses hides the one-clock lag of that enable.

Top module: `hostbus_slave`

## Requirements
- R1: Synchronous reset clears freq_word and wave_rdata to 0 and drops bus_rdata_en.
- R2: bus_rdata_en is high in the cycle after an edge that sampled bus_cs_n and bus_oe_n both low, and low in the cycle after any other edge.
- R3: In a read access, bus_rdata holds acquisition buffer word bus_addr[7:0] from access edge 10 until the access ends, ready for the host's sample at edge 11. Address bits 12:8 do not affect reads.
- R4: The returned word is the buffer content before access edge 9. Acquisition writes to that word on edge 9 or later do not change the word returned in that access, but a later read returns the new content.
- R5: A write commits bus_wdata at access edge 11 only when bus_cs_n and bus_we_n are both sampled low there. Addresses 0x000 to 0x0FF write waveform word bus_addr[7:0].
- R6: An access with bus_we_n held high changes no stored word.
- R7: At most one commit per access. Changes on bus_wdata after access edge 11 while chip select stays low do not alter the stored word.
- R8: Address decode: 0x100 selects the low half and 0x101 the high half of the frequency word. Any other address at or above 0x100, including any with bits 12:9 nonzero, is ignored on write.
- R9: A low-half write only stages its value. freq_word changes only on a high-half write, taking {high data, staged low} in one step.
- R10: wave_rdata returns waveform word wave_raddr one clock after the address is sampled. When a host write to the same word commits on the same edge, that edge returns the old word and the next edge returns the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output enable (read), active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | 13 | Word address |
| bus_wdata | input | 16 | Data from the host (pad input) |
| bus_rdata | output | 16 | Read data toward the pad |
| bus_rdata_en | output | 1 | Pad output enable for bus_rdata |
| acq_we | input | 1 | Acquisition buffer write strobe |
| acq_waddr | input | 8 | Acquisition buffer write address |
| acq_wdata | input | 16 | Acquisition buffer write data |
| wave_raddr | input | 8 | DDS-side waveform read address |
| wave_rdata | output | 16 | DDS-side waveform read data |
| freq_word | output | 32 | Frequency control word |

## Verification
Two pairs of functions can land on the same clock edge. In the first, a host write commits into the waveform RAM while the DDS port reads that same word. The bench aims wave_raddr at the target word of a write and samples wave_rdata after access edges 11 and 12, expecting the old value and then the new one. In the second, the capture port overwrites the acquisition word that a host read is fetching. The bench issues that write on access edge 10, expects the old word on the bus, and then expects the new word on the following read.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int HB_DATA_W    = 16;
  localparam int HB_ADDR_W    = 13;
  localparam int HB_BUF_AW    = 8;
  localparam int HB_ACC_CLKS  = 15;
  localparam int HB_RD_EDGE   = 11;
  localparam int HB_WR_EDGE   = 11;

  typedef enum logic [1:0] {
    RGN_NONE,
    RGN_WAVE,
    RGN_FREQ_LO,
    RGN_FREQ_HI
  } hb_rgn_e;
endpackage

// File: rtl/hb_access_timer.sv
// Counts bus clock edges since chip select was first sampled low and
// produces the read-load and write-commit strobes at fixed edges.
module hb_access_timer #(
  parameter int ACC_CLKS = 15,
  parameter int RD_EDGE  = 11,
  parameter int WR_EDGE  = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic we_n,
  output logic rd_load,
  output logic wr_fire
);
  localparam int CNT_W = $clog2(ACC_CLKS + 1);
  localparam logic [CNT_W-1:0] SAT    = CNT_W'(ACC_CLKS);
  localparam logic [CNT_W-1:0] RD_CNT = CNT_W'(RD_EDGE - 2);
  localparam logic [CNT_W-1:0] WR_CNT = CNT_W'(WR_EDGE - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cs_n) begin
      cnt <= '0;
    end else if (cnt != SAT) begin
      cnt <= cnt + 1'b1;
    end
  end

  // The edge after the counter shows N is access edge N+1.
  assign rd_load = !cs_n && (cnt == RD_CNT);
  assign wr_fire = !cs_n && !we_n && (cnt == WR_CNT);
endmodule

// File: rtl/hb_sdp_ram.sv
// Simple dual-port RAM, one write and one registered read port,
// read-first on address collision.
module hb_sdp_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/hb_freq_reg.sv
// Two-halves frequency word: the low half is staged, the high half
// write updates the whole word at once.
module hb_freq_reg #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] freq_word
);
  logic [DW-1:0] lo_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_stage  <= '0;
      freq_word <= '0;
    end else begin
      if (lo_we) lo_stage  <= wdata;
      if (hi_we) freq_word <= {wdata, lo_stage};
    end
  end
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
  import hb_pkg::*;
#(
  parameter int DATA_W   = HB_DATA_W,
  parameter int ADDR_W   = HB_ADDR_W,
  parameter int BUF_AW   = HB_BUF_AW,
  parameter int ACC_CLKS = HB_ACC_CLKS,
  parameter int RD_EDGE  = HB_RD_EDGE,
  parameter int WR_EDGE  = HB_WR_EDGE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_cs_n,
  input  logic                bus_oe_n,
  input  logic                bus_we_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rdata_en,
  input  logic                acq_we,
  input  logic [BUF_AW-1:0]   acq_waddr,
  input  logic [DATA_W-1:0]   acq_wdata,
  input  logic [BUF_AW-1:0]   wave_raddr,
  output logic [DATA_W-1:0]   wave_rdata,
  output logic [2*DATA_W-1:0] freq_word
);
  localparam int PAGE_W = ADDR_W - BUF_AW;
  localparam logic [PAGE_W-1:0] PAGE_WAVE = '0;
  localparam logic [PAGE_W-1:0] PAGE_CTRL = PAGE_W'(1);
  localparam logic [BUF_AW-1:0] OFS_LO    = '0;
  localparam logic [BUF_AW-1:0] OFS_HI    = BUF_AW'(1);

  logic              rd_load;
  logic              wr_fire;
  logic [PAGE_W-1:0] page;
  logic [BUF_AW-1:0] offs;
  hb_rgn_e           rgn;
  logic              wave_we;
  logic              freq_lo_we;
  logic              freq_hi_we;
  logic [DATA_W-1:0] acq_q;
  logic [DATA_W-1:0] dout_q;
  logic              den_q;

  hb_access_timer #(
    .ACC_CLKS (ACC_CLKS),
    .RD_EDGE  (RD_EDGE),
    .WR_EDGE  (WR_EDGE)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (bus_cs_n),
    .we_n    (bus_we_n),
    .rd_load (rd_load),
    .wr_fire (wr_fire)
  );

  assign page = bus_addr[ADDR_W-1:BUF_AW];
  assign offs = bus_addr[BUF_AW-1:0];

  always_comb begin
    rgn = RGN_NONE;
    if (page == PAGE_WAVE) begin
      rgn = RGN_WAVE;
    end else if (page == PAGE_CTRL) begin
      if (offs == OFS_LO)      rgn = RGN_FREQ_LO;
      else if (offs == OFS_HI) rgn = RGN_FREQ_HI;
    end
  end

  assign wave_we    = wr_fire && (rgn == RGN_WAVE);
  assign freq_lo_we = wr_fire && (rgn == RGN_FREQ_LO);
  assign freq_hi_we = wr_fire && (rgn == RGN_FREQ_HI);

  hb_sdp_ram #(
    .AW (BUF_AW),
    .DW (DATA_W)
  ) u_wave_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (wave_we),
    .waddr (offs),
    .wdata (bus_wdata),
    .raddr (wave_raddr),
    .rdata (wave_rdata)
  );

  hb_sdp_ram #(
    .AW (BUF_AW),
    .DW (DATA_W)
  ) u_acq_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (acq_we),
    .waddr (acq_waddr),
    .wdata (acq_wdata),
    .raddr (offs),
    .rdata (acq_q)
  );

  hb_freq_reg #(
    .DW (DATA_W)
  ) u_freq (
    .clk       (clk),
    .rst       (rst),
    .lo_we     (freq_lo_we),
    .hi_we     (freq_hi_we),
    .wdata     (bus_wdata),
    .freq_word (freq_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      den_q  <= 1'b0;
    end else begin
      den_q <= !bus_cs_n && !bus_oe_n;
      if (rd_load) dout_q <= acq_q;
    end
  end

  assign bus_rdata    = dout_q;
  assign bus_rdata_en = den_q;
endmodule

// File: rtl/hb_slave_chk.sv
module hb_slave_chk #(
  parameter int ACC_CLKS = 15,
  parameter int WR_EDGE  = 11,
  parameter int DATA_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_cs_n,
  input logic              bus_oe_n,
  input logic              bus_we_n,
  input logic              bus_rdata_en,
  input logic [2*DATA_W-1:0] freq_word,
  input logic              wr_fire,
  input logic              hi_we
);
  localparam int CNT_W = $clog2(ACC_CLKS + 1);
  localparam logic [CNT_W-1:0] SAT    = CNT_W'(ACC_CLKS);
  localparam logic [CNT_W-1:0] WR_CNT = CNT_W'(WR_EDGE - 1);

  logic [CNT_W-1:0] chk_cnt;
  logic [1:0]       chk_commits;

  always_ff @(posedge clk) begin
    if (rst || bus_cs_n) begin
      chk_cnt     <= '0;
      chk_commits <= '0;
    end else begin
      if (chk_cnt != SAT) chk_cnt <= chk_cnt + 1'b1;
      if (wr_fire && chk_commits != 2'd3) chk_commits <= chk_commits + 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (freq_word == '0 && !bus_rdata_en));

  assert_drive_on_R2: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && !bus_oe_n) |=> bus_rdata_en);

  assert_drive_off_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_cs_n || bus_oe_n) |=> !bus_rdata_en);

  assert_commit_edge_R5: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> (chk_cnt == WR_CNT && !bus_we_n && !bus_cs_n));

  assert_one_commit_R7: assert property (@(posedge clk) disable iff (rst)
    chk_commits <= 2'd1);

  assert_freq_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !hi_we |=> $stable(freq_word));
endmodule

bind hostbus_slave hb_slave_chk #(
  .ACC_CLKS (ACC_CLKS),
  .WR_EDGE  (WR_EDGE),
  .DATA_W   (DATA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_cs_n     (bus_cs_n),
  .bus_oe_n     (bus_oe_n),
  .bus_we_n     (bus_we_n),
  .bus_rdata_en (bus_rdata_en),
  .freq_word    (freq_word),
  .wr_fire      (wr_fire),
  .hi_we        (freq_hi_we)
);

// File: tb/hostbus_slave_tb.sv
module hostbus_slave_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_cs_n = 1'b1;
  logic        bus_oe_n = 1'b1;
  logic        bus_we_n = 1'b1;
  logic [12:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rdata_en;
  logic        acq_we = 1'b0;
  logic [7:0]  acq_waddr = '0;
  logic [15:0] acq_wdata = '0;
  logic [7:0]  wave_raddr = '0;
  logic [15:0] wave_rdata;
  logic [31:0] freq_word;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] wv_e11, wv_e12;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostbus_slave u_dut (
    .clk(clk), .rst(rst),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_en(bus_rdata_en),
    .acq_we(acq_we), .acq_waddr(acq_waddr), .acq_wdata(acq_wdata),
    .wave_raddr(wave_raddr), .wave_rdata(wave_rdata),
    .freq_word(freq_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic acq_load(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    acq_we = 1'b1; acq_waddr = a; acq_wdata = d;
    @(posedge clk);
    @(negedge clk);
    acq_we = 1'b0;
  endtask

  task automatic wave_peek(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    wave_raddr = a;
    @(posedge clk);
    @(negedge clk);
    d = wave_rdata;
  endtask

  // Host read; optionally the capture side overwrites the word on edge 10.
  task automatic host_read(input logic [12:0] a, input logic [15:0] exp,
                           input string req, input bit collide);
    @(negedge clk);
    bus_cs_n = 1'b0; bus_oe_n = 1'b0; bus_we_n = 1'b1; bus_addr = a;
    @(posedge clk);                       // access edge 1
    @(negedge clk);
    check("R2 enable on", {31'd0, bus_rdata_en}, 32'd1);
    repeat (8) @(posedge clk);            // edges 2..9
    @(negedge clk);
    if (collide) begin
      acq_we = 1'b1; acq_waddr = a[7:0]; acq_wdata = ~exp;
    end
    @(posedge clk);                       // edge 10
    @(negedge clk);
    acq_we = 1'b0;
    check(req, {16'd0, bus_rdata}, {16'd0, exp});
    repeat (4) @(posedge clk);            // edges 11..14
    @(negedge clk);
    bus_cs_n = 1'b1; bus_oe_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2 enable off", {31'd0, bus_rdata_en}, 32'd0);
    repeat (2) @(posedge clk);
  endtask

  // Host write; we_low=0 gives an access without write enable.
  task automatic host_write(input logic [12:0] a, input logic [15:0] d,
                            input bit we_low, input bit late_change);
    @(negedge clk);
    bus_cs_n = 1'b0; bus_oe_n = 1'b1; bus_we_n = ~we_low;
    bus_addr = a; bus_wdata = d;
    repeat (11) @(posedge clk);           // edges 1..11
    @(negedge clk);
    wv_e11 = wave_rdata;
    check("R2 no drive in write", {31'd0, bus_rdata_en}, 32'd0);
    if (late_change) bus_wdata = ~d;
    @(posedge clk);                       // edge 12
    @(negedge clk);
    wv_e12 = wave_rdata;
    repeat (2) @(posedge clk);            // edges 13, 14
    @(negedge clk);
    bus_cs_n = 1'b1; bus_we_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 freq_word", freq_word, 32'd0);
    check("R1 wave_rdata", {16'd0, wave_rdata}, 32'd0);
    check("R1 enable", {31'd0, bus_rdata_en}, 32'd0);
  endtask

  task automatic t_read;
    acq_load(8'h03, 16'h1234);
    acq_load(8'hFF, 16'hBEEF);
    host_read(13'h003, 16'h1234, "R3 read word 3", 1'b0);
    host_read(13'h0FF, 16'hBEEF, "R3 read word FF", 1'b0);
    host_read(13'h1003, 16'h1234, "R3 upper address bits", 1'b0);
  endtask

  task automatic t_read_collide;
    acq_load(8'h07, 16'hAAAA);
    host_read(13'h007, 16'hAAAA, "R4 old word on collision", 1'b1);
    host_read(13'h007, 16'h5555, "R4 new word next read", 1'b0);
  endtask

  task automatic t_write_wave;
    logic [15:0] v;
    host_write(13'h000, 16'h0A0A, 1'b1, 1'b0);
    host_write(13'h0FF, 16'hF0F0, 1'b1, 1'b0);
    wave_peek(8'h00, v);
    check("R5 wave word 0", {16'd0, v}, 32'h0A0A);
    wave_peek(8'hFF, v);
    check("R5 wave word FF", {16'd0, v}, 32'hF0F0);
    @(negedge clk);
    wave_raddr = 8'h10;
    host_write(13'h010, 16'h1111, 1'b1, 1'b0);
    host_write(13'h010, 16'h2222, 1'b1, 1'b0);
    check("R10 old word on commit edge", {16'd0, wv_e11}, 32'h1111);
    check("R10 new word next edge", {16'd0, wv_e12}, 32'h2222);
  endtask

  task automatic t_no_we;
    logic [15:0] v;
    host_write(13'h020, 16'h3333, 1'b1, 1'b0);
    host_write(13'h020, 16'hDEAD, 1'b0, 1'b0);
    wave_peek(8'h20, v);
    check("R6 no write enable", {16'd0, v}, 32'h3333);
  endtask

  task automatic t_once;
    logic [15:0] v;
    host_write(13'h030, 16'h4444, 1'b1, 1'b1);
    wave_peek(8'h30, v);
    check("R7 single commit", {16'd0, v}, 32'h4444);
  endtask

  task automatic t_freq_decode;
    logic [15:0] v;
    host_write(13'h040, 16'h7777, 1'b1, 1'b0);
    host_write(13'h1040, 16'h9999, 1'b1, 1'b0);
    wave_peek(8'h40, v);
    check("R8 high page ignored", {16'd0, v}, 32'h7777);
    host_write(13'h100, 16'h5678, 1'b1, 1'b0);
    check("R9 low half only staged", freq_word, 32'd0);
    host_write(13'h101, 16'h1234, 1'b1, 1'b0);
    check("R9 word after high half", freq_word, 32'h12345678);
    host_write(13'h101, 16'hABCD, 1'b1, 1'b0);
    check("R9 staged low kept", freq_word, 32'hABCD5678);
    host_write(13'h102, 16'hFFFF, 1'b1, 1'b0);
    host_write(13'h1101, 16'hFFFF, 1'b1, 1'b0);
    check("R8 other control addresses", freq_word, 32'hABCD5678);
    host_write(13'h100, 16'h0000, 1'b1, 1'b0);
    check("R9 low write leaves word", freq_word, 32'hABCD5678);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_read();
    t_read_collide();
    t_write_wave();
    t_no_we();
    t_once();
    t_freq_decode();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule